// File: doc/BRIEF.md
# Card Configuration Register Block

This block holds the configuration registers of a removable storage card attached to a host through a byte-wide attribute-memory bus. The host reaches four 8-bit registers at even attribute addresses starting at a base address. It writes a register by holding chip enable and the attribute-space select low and pulling write enable low. It reads a register by pulling output enable low instead. The block keeps a configuration index, a soft-reset control bit, an 8-bit-I/O request bit and a socket/copy register. It drives the card-wide reset, a "configured" indication and the drive number used by the task-file logic.

The soft-reset bit resets the card in the same way as the hardware reset pin, with one difference: the reset it causes does not clear the bit itself. The card stays in reset until the host writes the bit back to 0. At that point every register is at its power-up value and the card is unconfigured. Only the four register addresses accept writes. Every other attribute address is treated as reserved.

Top module: `cardcfg_regs`

## Requirements
- R1: While the hardware reset input is high, and after it falls, every register reads 0, `configured_o` is 0, `drive_num_o` is 0, and `card_rst_o` is 1 from the first clock edge after the reset input rises.
- R2: Register 0 (offset 0x200) holds the configuration index in bits [5:0]. Writing a nonzero index with bit 7 at 0 sets `configured_o` from the write edge on, and the index reads back with bits [7:6] at 0.
- R3: Writing bit 7 of offset 0x200 to 1 clears the index in the same write, so `configured_o` drops. `card_rst_o` rises on the clock edge after the write.
- R4: The soft-reset bit is not cleared by the reset it causes. Offset 0x200 reads 0x80 until the host writes bit 7 to 0.
- R5: While the soft-reset bit is 1, the index field of writes to 0x200 and all writes to 0x202 and 0x206 are ignored.
- R6: Writing bit 7 of 0x200 back to 0 clears `card_rst_o` one clock later. It leaves every register at 0 and `configured_o` at 0. The index field of that releasing write is not loaded.
- R7: The 8-bit-I/O request is bit 5 of offset 0x202. It reads back as written, every other bit of 0x202 reads 0, and it changes no output.
- R8: Offset 0x206 holds the copy field in bits [6:4] and the socket field in bits [3:0]. Bit 7 reads 0. `drive_num_o` equals bit 4, the low copy bit.
- R9: Writes to odd addresses, to offset 0x204 or to any address outside 0x200..0x207 change no register. Odd addresses and 0x204 read 0.
- R10: A write commits once, on the first clock edge at which write enable is seen low after being high. It commits only if chip enable and the attribute select are both low at that edge.
- R11: A hardware reset clears the soft-reset bit as well as every other field.
- R12: `rdata_o` is 0 unless chip enable, attribute select and output enable are all low, write enable is high and the address hits a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| hw_rst_i | input | 1 | Hardware reset pin, active high |
| ce_n_i | input | 1 | Chip enable, active low |
| reg_n_i | input | 1 | Attribute-space select, active low |
| oe_n_i | input | 1 | Output enable (read strobe), active low |
| we_n_i | input | 1 | Write enable (write strobe), active low |
| addr_i | input | ADDR_W | Attribute byte address |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte, 0 when not reading a register |
| card_rst_o | output | 1 | Registered card-wide reset |
| configured_o | output | 1 | High while the configuration index is nonzero |
| drive_num_o | output | 1 | Drive number taken from the copy field |

## Verification
A wrong internal state shows up at the ports right away. A corrupted index is visible on `configured_o` from the edge that stored it. A corrupted copy field is visible on `drive_num_o` in the same way. A soft-reset bit that is lost or stuck shows on `card_rst_o` one edge after the fault, and on the read value of offset 0x200 at the next read. A write that slips through during soft reset, or an index loaded by the releasing write, is caught by reading the registers back right after the release.

// File: rtl/cardcfg_pkg.sv
package cardcfg_pkg;

    localparam int DATA_W   = 8;
    localparam int IDX_W    = 6;
    localparam int COPY_W   = 3;
    localparam int SOCK_W   = 4;

    // bit positions the host software relies on
    localparam int SRST_BIT = 7;
    localparam int IO8_BIT  = 5;
    localparam int COPY_LSB = 4;

    typedef enum logic [1:0] {
        SEL_OPTION = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_PINREP = 2'd2,
        SEL_SOCKET = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic              srst;
        logic [IDX_W-1:0]  idx;
        logic              io8;
        logic [COPY_W-1:0] copy;
        logic [SOCK_W-1:0] sock;
    } cfg_state_t;

endpackage

// File: rtl/cardcfg_decode.sv
module cardcfg_decode #(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] CFG_BASE = 11'h200
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        ce_n_i,
    input  logic                        reg_n_i,
    input  logic                        oe_n_i,
    input  logic                        we_n_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic                        wr_stb_o,
    output logic                        rd_en_o,
    output cardcfg_pkg::cfg_sel_e       sel_o
);
    import cardcfg_pkg::*;

    localparam logic [ADDR_W-4:0] BASE_HI = CFG_BASE[ADDR_W-1:3];

    typedef struct packed {
        logic we_seen_high;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       hit;
    logic       access;

    always_comb begin
        hit      = (addr_i[ADDR_W-1:3] == BASE_HI) && !addr_i[0];
        access   = !ce_n_i && !reg_n_i;
        sel_o    = cfg_sel_e'(addr_i[2:1]);
        wr_stb_o = hit && access && !we_n_i && st_q.we_seen_high;
        rd_en_o  = hit && access && !oe_n_i && we_n_i;
        st_d.we_seen_high = we_n_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.we_seen_high <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // one write per strobe assertion
    assert_single_commit_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_stb_o |=> !wr_stb_o);

endmodule

// File: rtl/cardcfg_regfile.sv
module cardcfg_regfile (
    input  logic                                 clk_i,
    input  logic                                 rst_i,
    input  logic                                 wr_stb_i,
    input  logic                                 rd_en_i,
    input  cardcfg_pkg::cfg_sel_e                sel_i,
    input  logic [cardcfg_pkg::DATA_W-1:0]       wdata_i,
    output cardcfg_pkg::cfg_state_t              state_o,
    output logic [cardcfg_pkg::DATA_W-1:0]       rdata_o
);
    import cardcfg_pkg::*;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb_i) begin
            case (sel_i)
                SEL_OPTION: begin
                    st_d.srst = wdata_i[SRST_BIT];
                    if (!st_q.srst) st_d.idx = wdata_i[IDX_W-1:0];
                end
                SEL_STATUS: begin
                    if (!st_q.srst) st_d.io8 = wdata_i[IO8_BIT];
                end
                SEL_SOCKET: begin
                    if (!st_q.srst) begin
                        st_d.copy = wdata_i[COPY_LSB+COPY_W-1:COPY_LSB];
                        st_d.sock = wdata_i[SOCK_W-1:0];
                    end
                end
                default: ;
            endcase
        end
        // soft reset acts like the reset pin on every field except itself
        if (st_d.srst) begin
            st_d.idx  = '0;
            st_d.io8  = 1'b0;
            st_d.copy = '0;
            st_d.sock = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (sel_i)
                SEL_OPTION: rdata_o = {st_q.srst, 1'b0, st_q.idx};
                SEL_STATUS: rdata_o = {2'b00, st_q.io8, 5'b00000};
                SEL_SOCKET: rdata_o = {1'b0, st_q.copy, st_q.sock};
                default:    rdata_o = '0;
            endcase
        end
    end

    assign state_o = st_q;

    // the bit survives the reset it causes
    assert_srst_sticky_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.srst && !(wr_stb_i && sel_i == SEL_OPTION)) |=> st_q.srst);

    // no strobe, no change
    assert_no_stray_update_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_stb_i |=> $stable(st_q));

    // writes other than to the option register are shut out during soft reset
    assert_locked_in_srst_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.srst && wr_stb_i && sel_i != SEL_OPTION) |=> $stable(st_q));

endmodule

// File: rtl/cardcfg_regs.sv
module cardcfg_regs #(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] CFG_BASE = 11'h200
) (
    input  logic              clk_i,
    input  logic              hw_rst_i,
    input  logic              ce_n_i,
    input  logic              reg_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              card_rst_o,
    output logic              configured_o,
    output logic              drive_num_o
);
    import cardcfg_pkg::*;

    logic       wr_stb;
    logic       rd_en;
    cfg_sel_e   sel;
    cfg_state_t state;
    logic       rst_d, rst_q;

    cardcfg_decode #(
        .ADDR_W   (ADDR_W),
        .CFG_BASE (CFG_BASE)
    ) u_decode (
        .clk_i    (clk_i),
        .rst_i    (hw_rst_i),
        .ce_n_i   (ce_n_i),
        .reg_n_i  (reg_n_i),
        .oe_n_i   (oe_n_i),
        .we_n_i   (we_n_i),
        .addr_i   (addr_i),
        .wr_stb_o (wr_stb),
        .rd_en_o  (rd_en),
        .sel_o    (sel)
    );

    cardcfg_regfile u_regs (
        .clk_i    (clk_i),
        .rst_i    (hw_rst_i),
        .wr_stb_i (wr_stb),
        .rd_en_i  (rd_en),
        .sel_i    (sel),
        .wdata_i  (wdata_i),
        .state_o  (state),
        .rdata_o  (rdata_o)
    );

    always_comb begin
        rst_d = state.srst;
    end

    always_ff @(posedge clk_i) begin
        if (hw_rst_i) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= rst_d;
        end
    end

    assign card_rst_o   = rst_q;
    assign configured_o = |state.idx;
    assign drive_num_o  = state.copy[0];

    assert_hw_reset_drives_R1: assert property (@(posedge clk_i)
        hw_rst_i |=> card_rst_o);

    assert_srst_follows_R3: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        state.srst |=> card_rst_o);

    assert_unconfigured_in_reset_R3: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        state.srst |-> !configured_o && !drive_num_o);

    assert_release_clean_R6: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        $fell(card_rst_o) |-> !configured_o && !drive_num_o);

endmodule

// File: tb/cardcfg_regs_tb_top.sv
`timescale 1ns/1ps
module cardcfg_regs_tb_top;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          hw_rst = 1'b1;
    logic          ce_n = 1'b1, reg_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          card_rst, configured, drive_num;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    cardcfg_regs #(.ADDR_W(AW), .CFG_BASE(11'h200)) dut_i (
        .clk_i(clk), .hw_rst_i(hw_rst), .ce_n_i(ce_n), .reg_n_i(reg_n),
        .oe_n_i(oe_n), .we_n_i(we_n), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .card_rst_o(card_rst), .configured_o(configured),
        .drive_num_o(drive_num)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; ce_n = 0; reg_n = 0;
        @(negedge clk); we_n = 0;
        @(negedge clk); we_n = 1; ce_n = 1; reg_n = 1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; ce_n = 0; reg_n = 0; oe_n = 0;
        #1 d = rdata;
        oe_n = 1; ce_n = 1; reg_n = 1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hw_rst = 1;
        repeat (3) @(negedge clk);
        check("R1 card_rst in hw reset", {7'd0, card_rst}, 8'h01);
        check("R11 srst cleared by hw reset", {7'd0, configured}, 8'h00);
        hw_rst = 0;
        @(negedge clk);
        check("R1 card_rst released", {7'd0, card_rst}, 8'h00);
        check("R1 drive_num", {7'd0, drive_num}, 8'h00);
        for (int i = 0; i < 4; i++) begin
            rd(11'h200 + 11'(2*i), v);
            check("R1 reg reset value", v, 8'h00);
        end
    endtask

    task automatic t_config();
        logic [7:0] v;
        wr(11'h200, 8'h45);
        check("R2 configured", {7'd0, configured}, 8'h01);
        rd(11'h200, v);
        check("R2 index readback", v, 8'h05);
        check("R2 no reset", {7'd0, card_rst}, 8'h00);
    endtask

    task automatic t_copy();
        logic [7:0] v;
        wr(11'h206, 8'h95);
        check("R8 drive 1", {7'd0, drive_num}, 8'h01);
        rd(11'h206, v);
        check("R8 socket/copy readback", v, 8'h15);
        wr(11'h206, 8'h26);
        check("R8 drive 0", {7'd0, drive_num}, 8'h00);
        rd(11'h206, v);
        check("R8 readback 2", v, 8'h26);
        wr(11'h206, 8'h13);
    endtask

    task automatic t_io8();
        logic [7:0] v;
        wr(11'h202, 8'hFF);
        rd(11'h202, v);
        check("R7 io8 readback", v, 8'h20);
        check("R7 configured unchanged", {7'd0, configured}, 8'h01);
        check("R7 drive unchanged", {7'd0, drive_num}, 8'h01);
        wr(11'h202, 8'h00);
        rd(11'h202, v);
        check("R7 io8 cleared", v, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(11'h201, 8'h00);
        wr(11'h207, 8'h00);
        wr(11'h204, 8'hFF);
        wr(11'h100, 8'h00);
        wr(11'h600, 8'h00);
        rd(11'h200, v);
        check("R9 index kept", v, 8'h05);
        rd(11'h206, v);
        check("R9 socket kept", v, 8'h13);
        rd(11'h204, v);
        check("R9 0x204 reads 0", v, 8'h00);
        rd(11'h201, v);
        check("R9 odd reads 0", v, 8'h00);
    endtask

    task automatic t_gating();
        logic [7:0] v;
        // strobe without chip enable
        @(negedge clk); addr = 11'h200; wdata = 8'h00; ce_n = 1; reg_n = 0;
        @(negedge clk); we_n = 0;
        @(negedge clk); we_n = 1; reg_n = 1;
        check("R10 no write without ce", {7'd0, configured}, 8'h01);
        // strobe outside attribute space
        @(negedge clk); ce_n = 0; reg_n = 1;
        @(negedge clk); we_n = 0;
        @(negedge clk); we_n = 1; ce_n = 1;
        check("R10 no write without reg", {7'd0, configured}, 8'h01);
        // read without output enable
        @(negedge clk); addr = 11'h200; ce_n = 0; reg_n = 0;
        #1 v = rdata;
        ce_n = 1; reg_n = 1;
        check("R12 no oe gives 0", v, 8'h00);
    endtask

    task automatic t_softreset();
        logic [7:0] v;
        wr(11'h200, 8'h87);
        check("R3 unconfigured on srst", {7'd0, configured}, 8'h00);
        check("R3 card_rst raised", {7'd0, card_rst}, 8'h01);
        check("R3 drive cleared", {7'd0, drive_num}, 8'h00);
        repeat (5) @(negedge clk);
        rd(11'h200, v);
        check("R4 srst held", v, 8'h80);
        wr(11'h206, 8'h10);
        wr(11'h202, 8'h20);
        wr(11'h200, 8'h83);
        check("R5 drive locked", {7'd0, drive_num}, 8'h00);
        rd(11'h206, v);
        check("R5 socket locked", v, 8'h00);
        rd(11'h202, v);
        check("R5 status locked", v, 8'h00);
        rd(11'h200, v);
        check("R5 index locked", v, 8'h80);
        check("R4 still in reset", {7'd0, card_rst}, 8'h01);
        wr(11'h200, 8'h07);
        check("R6 card_rst released", {7'd0, card_rst}, 8'h00);
        check("R6 unconfigured", {7'd0, configured}, 8'h00);
        rd(11'h200, v);
        check("R6 index not loaded", v, 8'h00);
        wr(11'h200, 8'h07);
        check("R6 configurable again", {7'd0, configured}, 8'h01);
    endtask

    task automatic t_hw_over_srst();
        logic [7:0] v;
        wr(11'h200, 8'h80);
        hw_rst = 1;
        repeat (2) @(negedge clk);
        hw_rst = 0;
        @(negedge clk);
        check("R11 card_rst low after hw reset", {7'd0, card_rst}, 8'h00);
        rd(11'h200, v);
        check("R11 srst cleared", v, 8'h00);
    endtask

    initial begin
        t_reset();
        t_config();
        t_copy();
        t_io8();
        t_reserved();
        t_gating();
        t_softreset();
        t_hw_over_srst();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule